// File: doc/BRIEF.md
# Fixed-rate two-wire telegram transmitter

This block sends a command telegram of 1 to 12 bytes over a two-wire serial link. One wire carries the data and the other a free-running clock. The link has no select line, so the far end finds the end of a frame from a short pause in the clock. For that reason every bit goes out at one fixed rate, and bytes follow each other with no gap. An output-enable signal is high only while a telegram is on the wire. At all other times the link drivers are released, so the block never drives against a node that is answering. When no telegram is on the wire, external pull resistors set the line levels.

The host loads the bytes through a write port. It then pulses `start_i` with a byte count, and sets `reset_cmd_i` when the telegram is a reset command. `busy_o` is high for the whole transfer and `done_o` pulses once when the transfer ends. After a reset telegram, the block waits out a blackout window before the next telegram may appear on the link. A start request that arrives during this window is accepted and then held until the window ends. A divider made from parameters turns the system clock into the bit rate. With the defaults, a 48 MHz system clock gives 2.4 Mbit/s and a blackout of 150 µs.

Top module: `tele_tx`

## Requirements
- R1: Bytes are sent in buffer order from index 0, and each byte goes out most significant bit first. Data changes only where the clock falls or where the enable rises, so it is stable at each rising clock edge.
- R2: Every bit lasts exactly 2*HALF_DIV system cycles, with the clock low for the first half and high for the second. A telegram of N bytes keeps `oe_o` high for exactly N*16*HALF_DIV cycles, with no gap between bytes.
- R3: While `oe_o` is low, both `sclk_o` and `sdata_o` are 0. The clock therefore idles low.
- R4: A start request with a count of 0 or a count above MAX_BYTES is ignored: `busy_o` stays 0 and `oe_o` stays low.
- R5: A start request made while `busy_o` is high is ignored. The telegram in progress keeps its length, and no second telegram follows it.
- R6: `done_o` is high for exactly one cycle, and that cycle comes right after the first cycle in which `oe_o` is low again.
- R7: After a telegram sent with `reset_cmd_i` set, `oe_o` stays low for at least HOLD_CYCLES cycles. A start request that arrives in that window is held and sent once the window ends. A telegram sent without the flag puts no blackout in place.
- R8: `busy_o` goes high in the cycle after a start is accepted. It stays high while the start waits and while `oe_o` is high, and it goes low when `oe_o` falls.
- R9: After reset, `oe_o`, `sclk_o`, `sdata_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the telegram buffer |
| wr_addr_i | input | 4 | Buffer byte index to write |
| wr_data_i | input | 8 | Byte to write |
| start_i | input | 1 | Start request |
| count_i | input | 4 | Number of bytes to send (1..MAX_BYTES) |
| reset_cmd_i | input | 1 | Telegram is a reset command; starts the blackout after it |
| busy_o | output | 1 | Transfer accepted and not yet finished |
| done_o | output | 1 | One-cycle pulse after the enable is released |
| oe_o | output | 1 | Output enable of the link drivers |
| sclk_o | output | 1 | Serial clock wire |
| sdata_o | output | 1 | Serial data wire |

## Verification
The bench builds the block with HALF_DIV=2, MAX_BYTES=12 and HOLD_CYCLES=50. A bit therefore lasts four cycles, and the full 12-byte telegram (96 bits) fits in a few hundred cycles. Because the window is short, many random telegrams of random length, both with and without the reset flag, fit in one run. The short window also lets the bench place start requests inside and just after the blackout, and check the gap at the enable exactly.

// File: rtl/tele_tx.sv
module tele_tx #(
  parameter int HALF_DIV    = 10,
  parameter int MAX_BYTES   = 12,
  parameter int HOLD_CYCLES = 7200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       start_i,
  input  logic [3:0] count_i,
  input  logic       reset_cmd_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       oe_o,
  output logic       sclk_o,
  output logic       sdata_o
);
  localparam int PER = 2 * HALF_DIV;
  localparam int PW  = $clog2(PER);
  localparam int HW  = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, WAIT, SEND} st_t;

  st_t             st_q;
  logic [7:0]      mem_q [MAX_BYTES];
  logic [PW-1:0]   ph_q;
  logic [2:0]      bit_q;
  logic [3:0]      byte_q;
  logic [3:0]      nbytes_q;
  logic            rstf_q;
  logic [HW-1:0]   hold_q;
  logic            fin_q;
  logic            done_q;

  wire accept  = (st_q == IDLE) && start_i && (count_i != 4'd0) &&
                 (32'(count_i) <= MAX_BYTES);
  wire bit_end = (32'(ph_q) == PER - 1);

  always_ff @(posedge clk) begin
    if (wr_en_i && 32'(wr_addr_i) < MAX_BYTES)
      mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= IDLE;
      ph_q     <= '0;
      bit_q    <= 3'd7;
      byte_q   <= '0;
      nbytes_q <= '0;
      rstf_q   <= 1'b0;
      hold_q   <= '0;
      fin_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      fin_q  <= 1'b0;
      done_q <= fin_q;
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      case (st_q)
        IDLE: if (accept) begin
          nbytes_q <= count_i;
          rstf_q   <= reset_cmd_i;
          ph_q     <= '0;
          bit_q    <= 3'd7;
          byte_q   <= '0;
          st_q     <= (hold_q != '0) ? WAIT : SEND;
        end
        WAIT: if (hold_q == '0) st_q <= SEND;
        SEND: begin
          if (bit_end) begin
            ph_q <= '0;
            if (bit_q == 3'd0) begin
              bit_q <= 3'd7;
              if (byte_q == nbytes_q - 1'b1) begin
                st_q  <= IDLE;
                fin_q <= 1'b1;
                if (rstf_q) hold_q <= HW'(HOLD_CYCLES);
              end else begin
                byte_q <= byte_q + 1'b1;
              end
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  assign oe_o    = (st_q == SEND);
  assign busy_o  = (st_q != IDLE);
  assign done_o  = done_q;
  assign sclk_o  = oe_o && (32'(ph_q) >= HALF_DIV);
  assign sdata_o = oe_o && mem_q[byte_q][bit_q];
endmodule

// File: rtl/tele_tx_chk.sv
module tele_tx_chk #(
  parameter int HOLD_CYCLES = 7200,
  parameter int MAX_BYTES   = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [3:0] count_i,
  input logic       reset_cmd_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       oe_o,
  input logic       sclk_o,
  input logic       sdata_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  logic          flag_q;
  logic [HW-1:0] blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      if (!busy_o && start_i && count_i != 4'd0 && 32'(count_i) <= MAX_BYTES)
        flag_q <= reset_cmd_i;
      if ($fell(oe_o) && flag_q) blk_q <= HW'(HOLD_CYCLES - 1);
      else if (blk_q != '0)      blk_q <= blk_q - 1'b1;
    end
  end

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (!sclk_o && !sdata_o));
  p_data_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $past(oe_o) && !$fell(sclk_o)) |-> $stable(sdata_o));
  p_done_after_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!$past(oe_o) && $past(oe_o, 2)));
  p_busy_covers_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> busy_o);
  p_bad_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (count_i == 4'd0 || 32'(count_i) > MAX_BYTES)) |=> !busy_o);
  p_blackout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> (blk_q == '0));
endmodule

bind tele_tx tele_tx_chk #(.HOLD_CYCLES(HOLD_CYCLES), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
  .reset_cmd_i(reset_cmd_i), .busy_o(busy_o), .done_o(done_o),
  .oe_o(oe_o), .sclk_o(sclk_o), .sdata_o(sdata_o));

// File: tb/tb_tele_tx.sv
module tb_tele_tx;
  localparam int HALF = 2;
  localparam int MAXB = 12;
  localparam int HOLD = 50;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, rcmd = 0;
  logic [3:0] wr_addr = 0, count = 0;
  logic [7:0] wr_data = 0;
  logic busy, done, oe, sclk, sdata;

  tele_tx #(.HALF_DIV(HALF), .MAX_BYTES(MAXB), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .count_i(count),
    .reset_cmd_i(rcmd), .busy_o(busy), .done_o(done), .oe_o(oe),
    .sclk_o(sclk), .sdata_o(sdata));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic prev_oe = 0, prev_sclk = 0;
  int nbits = 0, oe_len = 0, last_rise = 0, per_bad = 0;
  int fall_cyc = -100, rise_cyc = 0, gap = 0, nframes = 0;
  int idle_bad = 0, done_bad = 0, busy_bad = 0;
  logic [95:0] bits;
  logic [7:0] exp_b [MAXB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (oe && !prev_oe) begin
      nbits = 0; oe_len = 0; per_bad = 0;
      rise_cyc = cyc; gap = cyc - fall_cyc; nframes++;
    end
    if (oe) begin
      oe_len++;
      if (!busy) busy_bad++;
      if (sclk && !prev_sclk) begin
        if (nbits > 0 && cyc - last_rise != 2*HALF) per_bad++;
        if (nbits == 0 && cyc - rise_cyc != HALF) per_bad++;
        if (nbits < 96) bits[95-nbits] = sdata;
        nbits++;
        last_rise = cyc;
      end
    end else begin
      if (sclk || sdata) idle_bad++;
    end
    if (!oe && prev_oe) begin
      fall_cyc = cyc;
      if (busy) busy_bad++;
    end
    if (done && cyc != fall_cyc + 1) done_bad++;
    prev_oe = oe; prev_sclk = sclk;
  end

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_addr = 4'(i); wr_data = exp_b[i];
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic pulse_start(input int n, input bit r);
    start = 1; count = 4'(n); rcmd = r;
    @(negedge clk);
    start = 0; rcmd = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1, "R6 done seen", int'(done), 1);
  endtask

  task automatic check_frame(input int n, input string tag);
    int exp_len = n * 16 * HALF;
    bit ok = 1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (bits[95 - (i*8 + (7-b))] !== exp_b[i][b]) ok = 0;
    chk(nbits == n*8, {tag, " R1 bit count"}, nbits, n*8);
    chk(ok, {tag, " R1 bit order/content"}, int'(ok), 1);
    chk(oe_len == exp_len && per_bad == 0, {tag, " R2 enable length"}, oe_len, exp_len);
  endtask

  task automatic send(input int n, input bit r, input string tag);
    for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
    load(n);
    pulse_start(n, r);
    chk(busy == 1, {tag, " R8 busy after accept"}, int'(busy), 1);
    wait_done();
    check_frame(n, tag);
  endtask

  initial begin : watchdog
    #400000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int nf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({oe, sclk, sdata, busy, done} == 5'b0, "R9 reset outputs",
        int'({oe, sclk, sdata, busy, done}), 0);
    rst_n = 1;
    @(negedge clk);

    exp_b[0] = 8'hA0; exp_b[1] = 8'h04; exp_b[2] = 8'h02; exp_b[3] = 8'hA9;
    load(4); pulse_start(4, 0); wait_done(); check_frame(4, "directed");
    exp_b[0] = 8'h80; load(1); pulse_start(1, 0); wait_done(); check_frame(1, "one byte");
    for (int i = 0; i < MAXB; i++) exp_b[i] = (i % 2) ? 8'h00 : 8'hFF;
    load(MAXB); pulse_start(MAXB, 0); wait_done(); check_frame(MAXB, "max length");

    nf = nframes;
    pulse_start(0, 0);
    chk(busy == 0, "R4 count zero busy", int'(busy), 0);
    pulse_start(13, 0);
    chk(busy == 0, "R4 count 13 busy", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk(nframes == nf, "R4 no frame", nframes - nf, 0);

    for (int i = 0; i < 3; i++) exp_b[i] = 8'(8'h5A + i);
    load(3); pulse_start(3, 0);
    repeat (5) @(negedge clk);
    pulse_start(7, 1);
    wait_done(); check_frame(3, "busy start");
    nf = nframes;
    repeat (HOLD + 20) @(negedge clk);
    chk(nframes == nf, "R5 no second frame", nframes - nf, 0);

    send(2, 1, "reset cmd");
    exp_b[0] = 8'h3C; load(1);
    pulse_start(1, 0);
    chk(busy == 1, "R7 held start busy", int'(busy), 1);
    wait_done(); check_frame(1, "after blackout");
    chk(gap > HOLD, "R7 blackout gap", gap, HOLD + 1);

    send(2, 0, "plain");
    exp_b[0] = 8'hC3; pulse_start(1, 0);
    wait_done();
    chk(gap < HOLD, "R7 no blackout without flag", gap, 3);

    for (int k = 0; k < 40; k++) begin
      int n = 1 + int'($urandom % MAXB);
      send(n, 1'($urandom % 4 == 0), "random");
    end

    chk(idle_bad == 0, "R3 idle lines low", idle_bad, 0);
    chk(done_bad == 0, "R6 done timing", done_bad, 0);
    chk(busy_bad == 0, "R8 busy framing", busy_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule